// File: doc/BRIEF.md
# Start/Stop Interval Measurement Core

This core times the gap between a start pulse and a stop pulse, typically the once-per-second (or ten-per-second) marks of two sources under comparison. A coarse counter runs on the 50 MHz measurement clock, so each coarse tick is 20 ns. An external interpolator splits every coarse period into 400 steps. For each edge it reports how many steps lie between the edge and the following clock edge. The core merges the coarse tick count with the two interpolator readings into one interval word in 50 ps units.

Each armed start edge opens one measurement. The stop edge closes it and fixes the coarse count. The core then waits for the interpolator strobe, which delivers the start and stop step counts. One cycle after that strobe it presents the combined interval. A stop that comes too soon after the start, a stop that coincides with the start, and a stop that never comes are reported on an error pulse, and none of them gives a result.

Top module: `interval_meter`

## Requirements
- R1: While reset is high, and on the first cycle after it, `resultOut`, `resultValid` and `errFlag` are all zero.
- R2: `startIn` and `stopIn` pass through two synchronising flops and act only on a low-to-high transition. A level held high never opens a second measurement. The coarse count equals the number of clock cycles between the rising edges of start and stop.
- R3: After the stop edge is accepted, the first cycle with `interpValid` high captures the result. `resultValid` is high on the next cycle, with `resultOut = coarse*400 + interpStart - interpStop`. Both interpolator words range from 0 to 399.
- R4: `resultValid` is a one-cycle pulse. `resultOut` keeps its value on every cycle where `resultValid` is low.
- R5: If the coarse count at stop is below 2, `errFlag` pulses for one cycle and no result follows. A coarse count of exactly 2 gives a normal result.
- R6: If the start and stop rising edges are detected in the same cycle while the core is idle and armed, `errFlag` pulses and no measurement opens.
- R7: If the coarse count reaches the timeout limit (default 10^8 clocks) with no stop, `errFlag` pulses and the core returns to idle. A stop detected in the same cycle the limit is reached takes priority and yields a result with coarse count equal to the limit.
- R8: While `armEn` is low in idle, start edges are ignored. A later stop and interpolator strobe then produce neither `resultValid` nor `errFlag`.
- R9: While a measurement is open, further start edges are ignored. An `interpValid` strobe before the stop edge is also ignored and does not end the measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz coarse measurement clock |
| rst | input | 1 | Synchronous reset, active high |
| armEn | input | 1 | Allows a start edge to open a measurement |
| startIn | input | 1 | Asynchronous start pulse |
| stopIn | input | 1 | Asynchronous stop pulse |
| interpStart | input | IW (9) | Interpolator steps from the start edge to the next clock edge |
| interpStop | input | IW (9) | Interpolator steps from the stop edge to the next clock edge |
| interpValid | input | 1 | Strobe marking both interpolator words valid |
| resultOut | output | RW (36) | Interval in 50 ps units |
| resultValid | output | 1 | One-cycle strobe for a new result |
| errFlag | output | 1 | One-cycle pulse for a too-short, coincident or timed-out measurement |

## Verification
Two pairs of decisions can fall on one clock edge. The first pair is the start and stop edges detected together. The second pair is a stop arriving on the exact cycle the timeout limit is reached. The bench provokes the first by raising both inputs on the same clock cycle and expects an error with no result. It provokes the second by placing the stop exactly the limit's number of cycles after the start, and expects a result whose coarse part equals the limit with no error. A behavioural model steps alongside the core on every clock, and per-scenario counts of results and errors are compared with values fixed from the requirements.

// File: rtl/intv_pkg.sv
package intv_pkg;

  // strobes from the controller to the datapath
  typedef struct packed {
    logic loadCoarse;  // restart coarse count at one
    logic incCoarse;   // advance coarse count
    logic capture;     // merge coarse and fine into the result
    logic raiseErr;    // pulse the error output
  } dpCmd_t;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_COUNT = 2'd1,
    PH_WAIT  = 2'd2
  } phase_t;

endpackage

// File: rtl/intv_edge_sync.sv
module intv_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic asyncIn,
  output logic risePulse
);
  logic [STAGES-1:0] chain;
  logic lastLvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain   <= '0;
      lastLvl <= 1'b0;
    end else begin
      chain   <= {chain[STAGES-2:0], asyncIn};
      lastLvl <= chain[STAGES-1];
    end
  end

  assign risePulse = chain[STAGES-1] & ~lastLvl;
endmodule

// File: rtl/intv_ctrl.sv
module intv_ctrl
  import intv_pkg::*;
#(
  parameter int CW           = 27,
  parameter int TIMEOUT_CLKS = 100000000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          armEn,
  input  logic          startRise,
  input  logic          stopRise,
  input  logic          interpValid,
  input  logic [CW-1:0] coarse,
  output dpCmd_t        cmd
);
  localparam logic [CW-1:0] LIMIT   = CW'(TIMEOUT_CLKS);
  localparam logic [CW-1:0] MIN_GAP = CW'(2);

  phase_t phase, phaseNext;

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_IDLE;
    else     phase <= phaseNext;
  end

  always_comb begin
    cmd       = '0;
    phaseNext = phase;
    case (phase)
      PH_IDLE: begin
        if (armEn && startRise) begin
          if (stopRise) begin
            cmd.raiseErr = 1'b1;
          end else begin
            cmd.loadCoarse = 1'b1;
            phaseNext      = PH_COUNT;
          end
        end
      end
      PH_COUNT: begin
        if (stopRise) begin
          if (coarse < MIN_GAP) begin
            cmd.raiseErr = 1'b1;
            phaseNext    = PH_IDLE;
          end else begin
            phaseNext = PH_WAIT;
          end
        end else if (coarse >= LIMIT) begin
          cmd.raiseErr = 1'b1;
          phaseNext    = PH_IDLE;
        end else begin
          cmd.incCoarse = 1'b1;
        end
      end
      PH_WAIT: begin
        if (interpValid) begin
          cmd.capture = 1'b1;
          phaseNext   = PH_IDLE;
        end
      end
      default: phaseNext = PH_IDLE;
    endcase
  end
endmodule

// File: rtl/intv_datapath.sv
module intv_datapath
  import intv_pkg::*;
#(
  parameter int CW    = 27,
  parameter int IW    = 9,
  parameter int RW    = 36,
  parameter int STEPS = 400
) (
  input  logic          clk,
  input  logic          rst,
  input  dpCmd_t        cmd,
  input  logic [IW-1:0] interpStart,
  input  logic [IW-1:0] interpStop,
  output logic [CW-1:0] coarse,
  output logic [RW-1:0] resultOut,
  output logic          resultValid,
  output logic          errFlag
);
  logic [RW-1:0] merged;

  assign merged = RW'(coarse) * RW'(STEPS) + RW'(interpStart) - RW'(interpStop);

  always_ff @(posedge clk) begin
    if (rst) begin
      coarse      <= '0;
      resultOut   <= '0;
      resultValid <= 1'b0;
      errFlag     <= 1'b0;
    end else begin
      if (cmd.loadCoarse)     coarse <= CW'(1);
      else if (cmd.incCoarse) coarse <= coarse + CW'(1);
      if (cmd.capture) resultOut <= merged;
      resultValid <= cmd.capture;
      errFlag     <= cmd.raiseErr;
    end
  end
endmodule

// File: rtl/interval_meter.sv
module interval_meter
  import intv_pkg::*;
#(
  parameter int STEPS        = 400,
  parameter int TIMEOUT_CLKS = 100000000,
  parameter int SYNC_STAGES  = 2,
  parameter int IW           = $clog2(STEPS),
  parameter int RW           = $clog2(TIMEOUT_CLKS + 1) + $clog2(STEPS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          armEn,
  input  logic          startIn,
  input  logic          stopIn,
  input  logic [IW-1:0] interpStart,
  input  logic [IW-1:0] interpStop,
  input  logic          interpValid,
  output logic [RW-1:0] resultOut,
  output logic          resultValid,
  output logic          errFlag
);
  localparam int CW = $clog2(TIMEOUT_CLKS + 1);

  logic          startRise, stopRise;
  logic [CW-1:0] coarseVal;
  dpCmd_t        cmd;

  intv_edge_sync #(.STAGES(SYNC_STAGES)) uStartSync (
    .clk(clk), .rst(rst), .asyncIn(startIn), .risePulse(startRise)
  );

  intv_edge_sync #(.STAGES(SYNC_STAGES)) uStopSync (
    .clk(clk), .rst(rst), .asyncIn(stopIn), .risePulse(stopRise)
  );

  intv_ctrl #(.CW(CW), .TIMEOUT_CLKS(TIMEOUT_CLKS)) uCtrl (
    .clk(clk), .rst(rst), .armEn(armEn), .startRise(startRise),
    .stopRise(stopRise), .interpValid(interpValid), .coarse(coarseVal),
    .cmd(cmd)
  );

  intv_datapath #(.CW(CW), .IW(IW), .RW(RW), .STEPS(STEPS)) uData (
    .clk(clk), .rst(rst), .cmd(cmd), .interpStart(interpStart),
    .interpStop(interpStop), .coarse(coarseVal), .resultOut(resultOut),
    .resultValid(resultValid), .errFlag(errFlag)
  );
endmodule

// File: rtl/intv_checker.sv
module intv_checker #(
  parameter int CW           = 27,
  parameter int RW           = 36,
  parameter int STEPS        = 400,
  parameter int TIMEOUT_CLKS = 100000000
) (
  input logic          clk,
  input logic          rst,
  input logic          resultValid,
  input logic          errFlag,
  input logic [RW-1:0] resultOut,
  input logic [CW-1:0] coarse
);
  // R5: a failed measurement never also produces a result
  p_valid_err_excl_r5: assert property (@(posedge clk) disable iff (rst)
    !(resultValid && errFlag));

  // R4: the result strobe lasts one cycle
  p_valid_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    resultValid |=> !resultValid);

  // R4: the result word holds while no new result is flagged
  p_hold_result_r4: assert property (@(posedge clk) disable iff (rst)
    !resultValid |-> $stable(resultOut));

  // R7: the coarse count never passes the timeout limit
  p_coarse_cap_r7: assert property (@(posedge clk) disable iff (rst)
    coarse <= CW'(TIMEOUT_CLKS));

  // R5: an accepted interval is at least two coarse ticks minus one fine span
  p_min_result_r5: assert property (@(posedge clk) disable iff (rst)
    resultValid |-> resultOut >= RW'(STEPS + 1));
endmodule

bind interval_meter intv_checker #(
  .CW(CW), .RW(RW), .STEPS(STEPS), .TIMEOUT_CLKS(TIMEOUT_CLKS)
) uChk (
  .clk(clk), .rst(rst), .resultValid(resultValid), .errFlag(errFlag),
  .resultOut(resultOut), .coarse(coarseVal)
);

// File: tb/tb_interval_meter.sv
module tb_interval_meter;
  localparam int TMO  = 40;
  localparam int STP  = 400;
  localparam int IWB  = $clog2(STP);
  localparam int RWB  = $clog2(TMO + 1) + $clog2(STP);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic armEn = 1'b1;
  logic startIn = 1'b0, stopIn = 1'b0, interpValid = 1'b0;
  logic [IWB-1:0] interpStart = '0, interpStop = '0;
  logic [RWB-1:0] resultOut;
  logic resultValid, errFlag;

  int total = 0, bad = 0;
  int dutV = 0, dutE = 0;
  string curReq = "R1";
  bit finished = 0;

  interval_meter #(.STEPS(STP), .TIMEOUT_CLKS(TMO)) dut (
    .clk(clk), .rst(rst), .armEn(armEn), .startIn(startIn), .stopIn(stopIn),
    .interpStart(interpStart), .interpStop(interpStop),
    .interpValid(interpValid), .resultOut(resultOut),
    .resultValid(resultValid), .errFlag(errFlag)
  );

  always #4 clk = ~clk;

  // behavioural reference model
  logic [3:0] sH = '0, pH = '0;
  int mPh = 0;
  longint mCnt = 0, expR = 0;
  bit expV = 0, expE = 0;

  always @(posedge clk) begin
    if (rst) begin
      sH = '0; pH = '0; mPh = 0; mCnt = 0; expR = 0; expV = 0; expE = 0;
    end else begin
      bit sE, pE;
      sH = {sH[2:0], startIn};
      pH = {pH[2:0], stopIn};
      sE = sH[2] & ~sH[3];
      pE = pH[2] & ~pH[3];
      expV = 0; expE = 0;
      case (mPh)
        0: if (armEn && sE) begin
             if (pE) expE = 1;
             else begin mPh = 1; mCnt = 1; end
           end
        1: if (pE) begin
             if (mCnt < 2) begin expE = 1; mPh = 0; end
             else mPh = 2;
           end else if (mCnt >= TMO) begin expE = 1; mPh = 0; end
           else mCnt++;
        default: if (interpValid) begin
             expV = 1; mPh = 0;
             expR = mCnt * STP + longint'(interpStart) - longint'(interpStop);
           end
      endcase
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (!rst && !finished) begin
      total++;
      if (resultValid !== expV || errFlag !== expE ||
          (expV && longint'(resultOut) != expR)) begin
        bad++;
        $display("FAIL %s: valid=%0b err=%0b res=%0d expected valid=%0b err=%0b res=%0d",
                 curReq, resultValid, errFlag, resultOut, expV, expE, expR);
      end
      if (resultValid) dutV++;
      if (errFlag) dutE++;
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // start rises now, stop rises gap cycles later
  task automatic runPair(int gap);
    startIn = 1'b1;
    if (gap == 0) stopIn = 1'b1;
    for (int i = 1; i <= gap + 4; i++) begin
      @(negedge clk);
      if (i == gap) stopIn = 1'b1;
      if (i == 3) startIn = 1'b0;
      if (i == gap + 3) stopIn = 1'b0;
    end
    tick(2);
  endtask

  task automatic sendInterp(int a, int b);
    interpStart = IWB'(a); interpStop = IWB'(b); interpValid = 1'b1;
    tick(1);
    interpValid = 1'b0;
    tick(3);
  endtask

  task automatic expectCounts(string req, int v0, int e0, int v, int e);
    check({req, " results"}, dutV - v0, v);
    check({req, " errors"},  dutE - e0, e);
  endtask

  initial begin
    int v0, e0;
    tick(3);
    // R1: outputs quiet in reset
    check("R1 valid", resultValid, 0);
    check("R1 err", errFlag, 0);
    check("R1 result", resultOut, 0);
    rst = 1'b0;
    tick(1);
    check("R1 after release", {resultValid, errFlag}, 0);
    tick(3);

    // R3: basic merge, hard value 10*400+123-45
    curReq = "R3"; v0 = dutV; e0 = dutE;
    runPair(10); sendInterp(123, 45);
    check("R3 value", resultOut, 4078);
    expectCounts("R3", v0, e0, 1, 0);

    // R3: fine extremes and other gaps
    v0 = dutV; e0 = dutE;
    runPair(7);  sendInterp(0, 399);
    check("R3 low fine", resultOut, 7*400 - 399);
    runPair(23); sendInterp(399, 0);
    check("R3 high fine", resultOut, 23*400 + 399);
    runPair(3);  sendInterp(250, 250);
    check("R3 equal fine", resultOut, 1200);
    expectCounts("R3 set", v0, e0, 3, 0);

    // R5: gap of one fails, gap of two passes
    curReq = "R5"; v0 = dutV; e0 = dutE;
    runPair(1); sendInterp(10, 10);
    expectCounts("R5 short", v0, e0, 0, 1);
    v0 = dutV; e0 = dutE;
    runPair(2); sendInterp(5, 399);
    check("R5 boundary", resultOut, 800 + 5 - 399);
    expectCounts("R5 boundary", v0, e0, 1, 0);

    // R6: coincident edges
    curReq = "R6"; v0 = dutV; e0 = dutE;
    runPair(0); sendInterp(1, 1);
    tick(TMO + 5);
    expectCounts("R6", v0, e0, 0, 1);

    // R7: timeout, then stop exactly at the limit
    curReq = "R7"; v0 = dutV; e0 = dutE;
    startIn = 1'b1; tick(3); startIn = 1'b0;
    tick(TMO + 6);
    expectCounts("R7 timeout", v0, e0, 0, 1);
    v0 = dutV; e0 = dutE;
    runPair(TMO); sendInterp(17, 3);
    check("R7 limit stop", resultOut, TMO*400 + 14);
    expectCounts("R7 limit stop", v0, e0, 1, 0);

    // R8: disarmed start ignored
    curReq = "R8"; v0 = dutV; e0 = dutE;
    armEn = 1'b0;
    runPair(9); sendInterp(30, 20);
    tick(TMO + 5);
    expectCounts("R8", v0, e0, 0, 0);
    armEn = 1'b1;

    // R9: second start and early strobe ignored
    curReq = "R9"; v0 = dutV; e0 = dutE;
    startIn = 1'b1; tick(3); startIn = 1'b0; tick(3);
    startIn = 1'b1;
    interpStart = 9'd77; interpStop = 9'd66; interpValid = 1'b1;
    tick(1); interpValid = 1'b0; tick(2); startIn = 1'b0;
    tick(6); stopIn = 1'b1; tick(3); stopIn = 1'b0; tick(3);
    sendInterp(200, 100);
    check("R9 value", resultOut, 15*400 + 100);
    expectCounts("R9", v0, e0, 1, 0);

    // R2: held start level opens only one measurement
    curReq = "R2"; v0 = dutV; e0 = dutE;
    startIn = 1'b1; tick(12); stopIn = 1'b1; tick(3); stopIn = 1'b0; tick(2);
    sendInterp(40, 40);
    check("R2 value", resultOut, 12*400);
    tick(TMO + 10);
    startIn = 1'b0; tick(4);
    expectCounts("R2", v0, e0, 1, 0);

    // R4: result held after the strobe
    check("R4 hold", resultOut, 12*400);
    check("R4 valid low", resultValid, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1200000;
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule